// File: doc/BRIEF.md
# Cache Flush and Write-Policy Sequencer

This block owns the enable state and the write policy (copy-back or write-through) of a four-way unified cache with 32-byte lines. It also runs the flush-all operation. The tag and data storage sit outside the block. The sequencer reaches them through a line-state port, which reads the valid and dirty bits of one line with one cycle of latency and can write them back. Dirty data leaves through a write-back port that uses a request and an acknowledge.

Software sends a command strobe with three flags: flush, disable and enable. A flush command starts a walk over every line. The walk goes through the sets in ascending order, and through ways 0 to 3 inside each set. A valid dirty line is written back, and after the acknowledge arrives the line is cleared. A valid clean line is invalidated. An invalid line is skipped. If the flush command carried the disable flag, the cache turns off in the same cycle that the walk ends.

The switch to write-through is accepted only when the cache is disabled and has been flushed since it was last enabled. Any other write-through request is refused with a one-cycle error pulse.

Top module: `cache_flush_seq`

## Requirements
- R1: After reset the cache is disabled, the policy is copy-back (`pol_wt`=0), `busy` is low and `flush_done` is low.
- R2: While idle, a command without the flush flag turns the cache off if `cmd_disable` is set, otherwise turns it on if `cmd_enable` is set, and the change is visible one clock later.
- R3: A flush visits line index = set*4 + way in ascending order, and each write-back address is the line index times 32 (byte address, low 5 bits zero).
- R4: For a valid dirty line, `wb_req` stays high with a stable `wb_addr` until `wb_ack`, and only then is the line's state written with valid=0 and dirty=0.
- R5: A valid clean line is invalidated with no write-back. An invalid line gets no state write. After a flush, every line is invalid.
- R6: `busy` is high from the clock after a flush command until the walk ends. Commands and policy requests that arrive while busy have no effect.
- R7: `flush_done` is a one-cycle pulse in the first idle cycle after the walk, which is the same cycle in which `busy` falls.
- R8: A flush with `cmd_disable` set leaves the cache disabled when it completes. Without that flag the enable state is unchanged.
- R9: A write-through request (`pol_req_wt`=1) is accepted only while the cache is disabled and has been flushed since it was last enabled. Otherwise the policy is unchanged and `pol_err` pulses for one cycle.
- R10: A copy-back request (`pol_req_wt`=0) made while idle is always accepted, with no error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cmd_valid | input | 1 | Command strobe |
| cmd_flush | input | 1 | Command: flush all lines |
| cmd_disable | input | 1 | Command: disable cache (after the flush, if flushing) |
| cmd_enable | input | 1 | Command: enable cache (non-flush commands only) |
| pol_req_valid | input | 1 | Policy change request strobe |
| pol_req_wt | input | 1 | Requested policy: 1 write-through, 0 copy-back |
| ls_rd_en | output | 1 | Line-state read strobe |
| ls_rd_idx | output | 6 | Line index to read |
| ls_valid | input | 1 | Valid bit of the line read last cycle |
| ls_dirty | input | 1 | Dirty bit of the line read last cycle |
| ls_wr_en | output | 1 | Line-state write strobe |
| ls_wr_idx | output | 6 | Line index to write |
| ls_wr_valid | output | 1 | Valid bit to write |
| ls_wr_dirty | output | 1 | Dirty bit to write |
| wb_req | output | 1 | Write-back request |
| wb_addr | output | 11 | Byte address of the line being written back |
| wb_ack | input | 1 | Write-back acknowledge |
| busy | output | 1 | Flush in progress |
| flush_done | output | 1 | One-cycle flush-complete pulse |
| cache_en | output | 1 | Cache enabled |
| pol_wt | output | 1 | Policy: 1 write-through, 0 copy-back |
| pol_err | output | 1 | One-cycle pulse: write-through request refused |

## Verification
The flush walk is exercised with several line-state contents. A random mix of invalid, clean and dirty lines shows whether the block sorts lines into skip, invalidate and write-back correctly. An empty cache and a fully dirty cache cover the two extremes: the first confirms that no spurious writes occur, and the second checks ordering and address formation on every line. Acknowledges arrive after random delays, which separates a design that holds its request from one that moves on too early. The policy requests are tried after reset, while enabled, after a flush that disables, and after a re-enable, which separates the rule "flushed since last enabled" from a plain check of whether the cache is disabled.

// File: rtl/flush_pkg.sv
package flush_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_READ,
        ST_EVAL,
        ST_WB,
        ST_CLR
    } seq_state_e;

    typedef struct packed {
        seq_state_e state;
        logic       dis_pend;
        logic       done;
    } seq_regs_t;

    typedef struct packed {
        logic en;
        logic wt;
        logic clean;
        logic err;
    } mode_regs_t;

endpackage

// File: rtl/flush_cursor.sv
module flush_cursor #(
    parameter int SETS = 16,
    parameter int WAYS = 4
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    clear_i,
    input  logic                    step_i,
    output logic [$clog2(SETS)-1:0] set_o,
    output logic [$clog2(WAYS)-1:0] way_o,
    output logic                    last_o
);
    localparam int SET_W = $clog2(SETS);
    localparam int WAY_W = $clog2(WAYS);
    localparam logic [SET_W-1:0] SET_LAST = SET_W'(SETS - 1);
    localparam logic [WAY_W-1:0] WAY_LAST = WAY_W'(WAYS - 1);

    logic [SET_W-1:0] set_d, set_q;
    logic [WAY_W-1:0] way_d, way_q;
    logic             way_wrap;

    assign way_wrap = (way_q == WAY_LAST);

    always_comb begin
        set_d = set_q;
        way_d = way_q;
        if (clear_i) begin
            set_d = '0;
            way_d = '0;
        end else if (step_i) begin
            if (way_wrap) begin
                way_d = '0;
                set_d = (set_q == SET_LAST) ? '0 : set_q + 1'b1;
            end else begin
                way_d = way_q + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            set_q <= '0;
            way_q <= '0;
        end else begin
            set_q <= set_d;
            way_q <= way_d;
        end
    end

    assign set_o  = set_q;
    assign way_o  = way_q;
    assign last_o = way_wrap && (set_q == SET_LAST);

    // R3: a step from a non-final way moves to the next way of the same set
    assert_way_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (step_i && !clear_i && !way_wrap) |=> (set_o == $past(set_o)));

endmodule

// File: rtl/mode_ctrl.sv
module mode_ctrl
    import flush_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic idle_i,
    input  logic cmd_valid_i,
    input  logic cmd_flush_i,
    input  logic cmd_disable_i,
    input  logic cmd_enable_i,
    input  logic pol_req_valid_i,
    input  logic pol_req_wt_i,
    input  logic fin_i,
    input  logic fin_disable_i,
    output logic cache_en_o,
    output logic pol_wt_o,
    output logic pol_err_o
);
    mode_regs_t m_d, m_q;

    always_comb begin
        m_d       = m_q;
        m_d.err   = 1'b0;
        // a line may become dirty in any cycle the cache is on
        m_d.clean = m_q.clean && !m_q.en;

        if (idle_i && cmd_valid_i && !cmd_flush_i) begin
            if (cmd_disable_i)
                m_d.en = 1'b0;
            else if (cmd_enable_i)
                m_d.en = 1'b1;
        end

        if (fin_i) begin
            if (fin_disable_i)
                m_d.en = 1'b0;
            if (fin_disable_i || !m_q.en)
                m_d.clean = 1'b1;
        end

        if (idle_i && pol_req_valid_i) begin
            if (!pol_req_wt_i)
                m_d.wt = 1'b0;
            else if (!m_q.en && m_q.clean)
                m_d.wt = 1'b1;
            else
                m_d.err = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            m_q <= '0;
        else
            m_q <= m_d;
    end

    assign cache_en_o = m_q.en;
    assign pol_wt_o   = m_q.wt;
    assign pol_err_o  = m_q.err;

    // R9: a refused request leaves the policy as it was
    assert_err_keeps_policy_R9: assert property (@(posedge clk) disable iff (!rst_n)
        pol_err_o |-> $stable(pol_wt_o));

    // R9: write-through is only entered from a disabled cache
    assert_wt_from_disabled_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pol_wt_o) |-> $past(!cache_en_o));

endmodule

// File: rtl/cache_flush_seq.sv
module cache_flush_seq
    import flush_pkg::*;
#(
    parameter int SETS       = 16,
    parameter int WAYS       = 4,
    parameter int LINE_BYTES = 32,
    localparam int SET_W     = $clog2(SETS),
    localparam int WAY_W     = $clog2(WAYS),
    localparam int IDX_W     = SET_W + WAY_W,
    localparam int OFF_W     = $clog2(LINE_BYTES),
    localparam int ADDR_W    = IDX_W + OFF_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    input  logic              cmd_flush,
    input  logic              cmd_disable,
    input  logic              cmd_enable,
    input  logic              pol_req_valid,
    input  logic              pol_req_wt,
    output logic              ls_rd_en,
    output logic [IDX_W-1:0]  ls_rd_idx,
    input  logic              ls_valid,
    input  logic              ls_dirty,
    output logic              ls_wr_en,
    output logic [IDX_W-1:0]  ls_wr_idx,
    output logic              ls_wr_valid,
    output logic              ls_wr_dirty,
    output logic              wb_req,
    output logic [ADDR_W-1:0] wb_addr,
    input  logic              wb_ack,
    output logic              busy,
    output logic              flush_done,
    output logic              cache_en,
    output logic              pol_wt,
    output logic              pol_err
);
    seq_regs_t        r_d, r_q;
    logic             cur_clear, cur_step, cur_last, fin;
    logic [SET_W-1:0] cur_set;
    logic [WAY_W-1:0] cur_way;
    logic [IDX_W-1:0] line_idx;
    logic             idle;

    flush_cursor #(.SETS(SETS), .WAYS(WAYS)) u_cursor (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear_i (cur_clear),
        .step_i  (cur_step),
        .set_o   (cur_set),
        .way_o   (cur_way),
        .last_o  (cur_last)
    );

    assign line_idx = {cur_set, cur_way};
    assign idle     = (r_q.state == ST_IDLE);

    always_comb begin
        r_d       = r_q;
        r_d.done  = 1'b0;
        cur_clear = 1'b0;
        cur_step  = 1'b0;
        fin       = 1'b0;
        ls_rd_en  = 1'b0;
        ls_wr_en  = 1'b0;
        wb_req    = 1'b0;
        unique case (r_q.state)
            ST_IDLE: begin
                if (cmd_valid && cmd_flush) begin
                    r_d.state    = ST_READ;
                    r_d.dis_pend = cmd_disable;
                    cur_clear    = 1'b1;
                end
            end
            ST_READ: begin
                ls_rd_en  = 1'b1;
                r_d.state = ST_EVAL;
            end
            ST_EVAL: begin
                if (ls_valid && ls_dirty)
                    r_d.state = ST_WB;
                else if (ls_valid)
                    r_d.state = ST_CLR;
                else if (cur_last) begin
                    r_d.state = ST_IDLE;
                    r_d.done  = 1'b1;
                    fin       = 1'b1;
                end else begin
                    cur_step  = 1'b1;
                    r_d.state = ST_READ;
                end
            end
            ST_WB: begin
                wb_req = 1'b1;
                if (wb_ack)
                    r_d.state = ST_CLR;
            end
            ST_CLR: begin
                ls_wr_en = 1'b1;
                if (cur_last) begin
                    r_d.state = ST_IDLE;
                    r_d.done  = 1'b1;
                    fin       = 1'b1;
                end else begin
                    cur_step  = 1'b1;
                    r_d.state = ST_READ;
                end
            end
            default: r_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.state    <= ST_IDLE;
            r_q.dis_pend <= 1'b0;
            r_q.done     <= 1'b0;
        end else begin
            r_q <= r_d;
        end
    end

    mode_ctrl u_mode (
        .clk             (clk),
        .rst_n           (rst_n),
        .idle_i          (idle),
        .cmd_valid_i     (cmd_valid),
        .cmd_flush_i     (cmd_flush),
        .cmd_disable_i   (cmd_disable),
        .cmd_enable_i    (cmd_enable),
        .pol_req_valid_i (pol_req_valid),
        .pol_req_wt_i    (pol_req_wt),
        .fin_i           (fin),
        .fin_disable_i   (r_q.dis_pend),
        .cache_en_o      (cache_en),
        .pol_wt_o        (pol_wt),
        .pol_err_o       (pol_err)
    );

    assign ls_rd_idx   = line_idx;
    assign ls_wr_idx   = line_idx;
    assign ls_wr_valid = 1'b0;
    assign ls_wr_dirty = 1'b0;
    assign wb_addr     = {line_idx, {OFF_W{1'b0}}};
    assign busy        = !idle;
    assign flush_done  = r_q.done;

    // R4: an unanswered write-back request is held with the same address
    assert_wb_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (wb_req && !wb_ack) |=> (wb_req && $stable(wb_addr)));

    // R4: an acknowledged write-back is followed by the state write of that line
    assert_clear_after_ack_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (wb_req && wb_ack) |=> (ls_wr_en && ls_wr_idx == $past(ls_rd_idx)));

    // R7: the completion pulse lasts a single cycle
    assert_done_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
        flush_done |=> !flush_done);

    // R7: completion coincides with the return to idle
    assert_done_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> flush_done);

    // R6: policy requests during a flush have no effect
    assert_busy_ignores_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && pol_req_valid) |=> ($stable(pol_wt) && !pol_err));

endmodule

// File: tb/tb_cache_flush_seq.sv
module tb_cache_flush_seq;
    localparam int CLK_PERIOD = 10;
    localparam int LINES      = 64;
    localparam int LOGSZ      = 1024;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 0, cmd_flush = 0, cmd_disable = 0, cmd_enable = 0;
    logic        pol_req_valid = 0, pol_req_wt = 0;
    logic        ls_rd_en, ls_wr_en, ls_wr_valid, ls_wr_dirty;
    logic [5:0]  ls_rd_idx, ls_wr_idx;
    logic        ls_valid = 0, ls_dirty = 0;
    logic        wb_req, wb_ack = 0;
    logic [10:0] wb_addr;
    logic        busy, flush_done, cache_en, pol_wt, pol_err;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    bit          mv [LINES];
    bit          md [LINES];
    logic [10:0] wlog [LOGSZ];
    int          logn = 0;
    int          wr_total = 0;
    int          bad_wr = 0;

    cache_flush_seq dut (
        .clk(clk), .rst_n(rst_n),
        .cmd_valid(cmd_valid), .cmd_flush(cmd_flush),
        .cmd_disable(cmd_disable), .cmd_enable(cmd_enable),
        .pol_req_valid(pol_req_valid), .pol_req_wt(pol_req_wt),
        .ls_rd_en(ls_rd_en), .ls_rd_idx(ls_rd_idx),
        .ls_valid(ls_valid), .ls_dirty(ls_dirty),
        .ls_wr_en(ls_wr_en), .ls_wr_idx(ls_wr_idx),
        .ls_wr_valid(ls_wr_valid), .ls_wr_dirty(ls_wr_dirty),
        .wb_req(wb_req), .wb_addr(wb_addr), .wb_ack(wb_ack),
        .busy(busy), .flush_done(flush_done),
        .cache_en(cache_en), .pol_wt(pol_wt), .pol_err(pol_err)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // line-state storage model with one cycle of read latency
    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (ls_rd_en) begin
            ls_valid <= mv[ls_rd_idx];
            ls_dirty <= md[ls_rd_idx];
        end
        if (ls_wr_en) begin
            wr_total <= wr_total + 1;
            if (!mv[ls_wr_idx]) bad_wr <= bad_wr + 1;
            mv[ls_wr_idx] <= ls_wr_valid;
            md[ls_wr_idx] <= ls_wr_dirty;
        end
        if (wb_req && wb_ack) begin
            wlog[logn % LOGSZ] <= wb_addr;
            logn <= logn + 1;
        end
    end

    // write-back responder with random delay
    always @(negedge clk) begin
        wb_ack <= wb_req && (($urandom % 3) == 0);
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int exp_addr(input int idx);
        return idx * 32;
    endfunction

    // mode: 0 random, 1 empty, 2 all dirty
    task automatic fill(input int mode);
        for (int i = 0; i < LINES; i++) begin
            bit v, d;
            v = (mode == 2) ? 1'b1 : (mode == 1) ? 1'b0 : 1'($urandom % 2);
            d = v && ((mode == 2) || (($urandom % 2) == 1));
            mv[i] <= v;
            md[i] <= d;
        end
        @(negedge clk);
    endtask

    task automatic cmd(input bit en, input bit dis);
        cmd_valid = 1; cmd_flush = 0; cmd_enable = en; cmd_disable = dis;
        @(negedge clk);
        cmd_valid = 0; cmd_enable = 0; cmd_disable = 0;
    endtask

    task automatic pol(input bit wt, input bit exp_err, input bit exp_wt, input string req);
        pol_req_valid = 1; pol_req_wt = wt;
        @(negedge clk);
        pol_req_valid = 0;
        chk(pol_err == exp_err, {req, " pol_err"}, int'(pol_err), int'(exp_err));
        chk(pol_wt == exp_wt, {req, " pol_wt"}, int'(pol_wt), int'(exp_wt));
        @(negedge clk);
        chk(pol_err == 1'b0, {req, " pol_err one cycle"}, int'(pol_err), 0);
    endtask

    task automatic flush(input bit dis, input bit inject);
        int exp_list[LINES];
        int nexp = 0;
        int nvalid = 0;
        int base, wbase, bbase, n;
        bit en_before, wt_before, busy_ok;
        for (int i = 0; i < LINES; i++) begin
            if (mv[i]) nvalid++;
            if (mv[i] && md[i]) begin
                exp_list[nexp] = exp_addr(i);
                nexp++;
            end
        end
        base = logn; wbase = wr_total; bbase = bad_wr;
        en_before = cache_en; wt_before = pol_wt;
        cmd_valid = 1; cmd_flush = 1; cmd_disable = dis; cmd_enable = 0;
        @(negedge clk);
        cmd_valid = 0; cmd_flush = 0; cmd_disable = 0;
        chk(busy == 1'b1, "R6 busy after flush command", int'(busy), 1);
        if (inject) begin
            repeat (3) @(negedge clk);
            // R6: these must be ignored while busy
            cmd_valid = 1; cmd_flush = 1; cmd_enable = !en_before; cmd_disable = en_before;
            pol_req_valid = 1; pol_req_wt = !wt_before;
            @(negedge clk);
            cmd_valid = 0; cmd_flush = 0; cmd_enable = 0; cmd_disable = 0;
            pol_req_valid = 0;
        end
        busy_ok = 1;
        n = 0;
        while (!flush_done && n < 5000) begin
            @(negedge clk);
            n++;
            if (!flush_done && !busy) busy_ok = 0;
        end
        chk(flush_done == 1'b1, "R7 flush_done seen", int'(flush_done), 1);
        chk(busy_ok, "R6 busy held during flush", int'(busy_ok), 1);
        chk(busy == 1'b0, "R7 busy low with flush_done", int'(busy), 0);
        chk(cache_en == (dis ? 1'b0 : en_before), "R8 enable after flush",
            int'(cache_en), int'(dis ? 1'b0 : en_before));
        chk(pol_wt == wt_before, "R6 policy unchanged by busy request",
            int'(pol_wt), int'(wt_before));
        @(negedge clk);
        chk(flush_done == 1'b0, "R7 flush_done single cycle", int'(flush_done), 0);
        chk(cache_en == (dis ? 1'b0 : en_before), "R6 command during busy ignored",
            int'(cache_en), int'(dis ? 1'b0 : en_before));
        chk(busy == 1'b0, "R6 no restart from ignored flush", int'(busy), 0);
        chk(logn - base == nexp, "R4 write-back count", logn - base, nexp);
        for (int k = 0; k < nexp && k < logn - base; k++) begin
            int a;
            a = int'(wlog[(base + k) % LOGSZ]);
            if (a != exp_list[k])
                chk(0, "R3 write-back order/address", a, exp_list[k]);
        end
        checks++;
        chk(wr_total - wbase == nvalid, "R5 state writes equal valid lines", wr_total - wbase, nvalid);
        chk(bad_wr == bbase, "R5 no write to invalid line", bad_wr - bbase, 0);
        n = 0;
        for (int i = 0; i < LINES; i++) if (mv[i] || md[i]) n++;
        chk(n == 0, "R5 all lines invalid after flush", n, 0);
    endtask

    initial begin
        while (cycles < 150000) @(posedge clk);
        chk(0, "watchdog", cycles, 150000);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'h5eed_1234));
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        chk(cache_en == 1'b0, "R1 reset cache_en", int'(cache_en), 0);
        chk(pol_wt == 1'b0, "R1 reset pol_wt", int'(pol_wt), 0);
        chk(busy == 1'b0, "R1 reset busy", int'(busy), 0);
        chk(flush_done == 1'b0, "R1 reset flush_done", int'(flush_done), 0);

        pol(1'b1, 1'b1, 1'b0, "R9 write-through refused after reset");
        pol(1'b0, 1'b0, 1'b0, "R10 copy-back accepted");

        cmd(1'b1, 1'b0);
        chk(cache_en == 1'b1, "R2 enable command", int'(cache_en), 1);

        fill(0);
        flush(1'b0, 1'b0);
        pol(1'b1, 1'b1, 1'b0, "R9 write-through refused while enabled");

        fill(0);
        flush(1'b1, 1'b1);
        pol(1'b1, 1'b0, 1'b1, "R9 write-through accepted after disabling flush");
        pol(1'b0, 1'b0, 1'b0, "R10 copy-back from write-through");
        pol(1'b1, 1'b0, 1'b1, "R9 write-through again while still clean");
        pol(1'b0, 1'b0, 1'b0, "R10 copy-back");

        cmd(1'b1, 1'b0);
        chk(cache_en == 1'b1, "R2 re-enable", int'(cache_en), 1);
        cmd(1'b1, 1'b1);
        chk(cache_en == 1'b0, "R2 disable wins over enable", int'(cache_en), 0);
        pol(1'b1, 1'b1, 1'b0, "R9 refused: not flushed since enable");

        fill(1);
        flush(1'b0, 1'b0);
        chk(cache_en == 1'b0, "R8 stays disabled without flag", int'(cache_en), 0);
        pol(1'b1, 1'b0, 1'b1, "R9 accepted after flush while disabled");
        pol(1'b0, 1'b0, 1'b0, "R10 copy-back restored");

        cmd(1'b1, 1'b0);
        fill(2);
        flush(1'b1, 1'b0);

        for (int it = 0; it < 4; it++) begin
            bit d;
            cmd(1'b1, 1'b0);
            chk(cache_en == 1'b1, "R2 enable in loop", int'(cache_en), 1);
            fill(0);
            d = 1'($urandom % 2);
            flush(d, 1'($urandom % 2));
            pol(1'b1, !d, d, "R9 policy after random flush");
            pol(1'b0, 1'b0, 1'b0, "R10 copy-back in loop");
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule